// File: doc/BRIEF.md
# UART Receive FIFO Controller with Character Timeout

This block sits between a UART's receive shifter and its receive buffer register. Each incoming byte arrives as a one-cycle beat on a valid/ready stream. In FIFO mode the bytes are kept in a 16-entry queue. In single-buffer mode they are kept in one holding register. Software drains the data through a read strobe on the output stream. FIFO control writes switch the mode, flush the queue and select the trigger threshold. The block reports data-ready, overrun, break, trigger-reached and character-timeout status on plain pins, and these feed an interrupt arbiter outside the block.

The input stream never applies back-pressure, because a shift register cannot hold a byte back. `in_ready` stays high. A byte that finds no room is dropped and flagged as an overrun. On the output side, `out_valid` shows that data is held. Asserting `out_ready` for one cycle is a read of the buffer register. A read when `out_valid` is low is legal and returns 0x00. A break strobe counts as an input beat carrying a zero byte, and it wins over `in_valid` in the same cycle. A FIFO control write in a cycle takes priority over any input beat in that cycle.

The timeout is counted in `baud_tick` pulses. Its length is four character times, and the character length comes from the line settings.

Top module: `uart_rx_fifo`

## Requirements
- R1: In FIFO mode, control bits 7:6 select the trigger threshold: code 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 entries. `trig_hit` is high exactly when `level` is at or above the threshold. In single-buffer mode `trig_hit` follows data-ready.
- R2: FIFO mode stores up to 16 bytes and returns them in arrival order. `level` reports 0 to 16 entries. A read and an accepted input beat in the same cycle both take effect, and `level` stays the same.
- R3: An input beat that arrives when the FIFO is full and no read happens in that cycle is discarded. The stored bytes stay unchanged and `overrun` is set. `overrun` stays set until a `stat_clr` pulse.
- R4: With the FIFO disabled (control bit 0 low), one holding register keeps the newest byte. A byte that arrives while data-ready is still set, with no read in the same cycle, sets `overrun`.
- R5: After every input beat, and after every read that leaves data behind, a timer restarts at 4 × N baud ticks. N = 1 + (5 + wlen) + parity_en + (stop2 ? 2 : 1). If the timer runs out while the FIFO holds data, `timeout_pend` is set. If the FIFO is empty at that point, nothing happens.
- R6: Any read clears `timeout_pend`. A read in FIFO mode with the FIFO empty returns 0x00 on `out_data`.
- R7: A read that leaves no data behind clears both data-ready and `brk`.
- R8: A control write with bit 1 set empties the FIFO. It clears data-ready, `brk` and `timeout_pend`, and it stops the timer.
- R9: A control write that changes bit 0 forces the same flush as R8. `fcr_q` keeps only bits 7, 6, 3 and 0 of the written value, and the other bits read back as zero.
- R10: A break strobe enters a 0x00 byte, following the same rules as a normal beat, and sets both `brk` and data-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One pulse per bit time; drives the timeout timer |
| lcr_wlen | input | 2 | Data bits minus 5 |
| lcr_par_en | input | 1 | Parity bit present |
| lcr_stop2 | input | 1 | Two stop bits when high |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_data | input | 8 | FIFO control write value |
| stat_clr | input | 1 | Status read: clears overrun and break |
| in_valid | input | 1 | Received byte beat |
| in_ready | output | 1 | Always high |
| in_data | input | 8 | Received byte |
| in_break | input | 1 | Break detected strobe |
| out_valid | output | 1 | Receive data held |
| out_ready | input | 1 | Buffer register read strobe |
| out_data | output | 8 | Byte returned by the read in this cycle |
| fcr_q | output | 8 | Retained control bits |
| level | output | 5 | FIFO entry count |
| trig_hit | output | 1 | Trigger threshold reached |
| data_ready | output | 1 | Data-ready status |
| overrun | output | 1 | Overrun status |
| brk | output | 1 | Break status |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
The hardest case to reach is a timeout that fires or stays quiet on exactly the right baud tick. This has to be shown for more than one line format, and also when the last read emptied the queue. The bench holds `baud_tick` high so that ticks equal clock cycles. It then counts edges from the last beat and checks `timeout_pend` one edge before and exactly at the expected expiry. A long random phase mixes input beats and reads, including same-cycle pairs and overruns on a full queue, and checks the result against a queue model kept in the bench.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  // Trigger threshold for the 2-bit selection code
  function automatic int trig_level(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // Bits per character: start + data + optional parity + stop
  function automatic int char_bits(input logic [1:0] wlen, input logic par_en,
                                   input logic stop2);
    return 1 + 5 + int'(wlen) + int'(par_en) + (stop2 ? 2 : 1);
  endfunction

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic [LVL_W-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end
  end

  assign dout = mem[rd_ptr];
endmodule

// File: rtl/uart_rxq_timer.sv
module uart_rxq_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          stop,
  input  logic [CW-1:0] reload,
  output logic          expire
);
  logic [CW-1:0] cnt;
  logic          armed;

  assign expire = armed && tick && (cnt == CW'(1)) && !restart && !stop;

  always_ff @(posedge clk) begin
    if (!rst_n || stop) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      cnt   <= reload;
      armed <= 1'b1;
    end else if (armed && tick) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int TO_W  = $clog2(4 * 12 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic [1:0]       lcr_wlen,
  input  logic             lcr_par_en,
  input  logic             lcr_stop2,
  input  logic             fcr_wr,
  input  logic [7:0]       fcr_data,
  input  logic             stat_clr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_break,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [7:0]       fcr_q,
  output logic [LVL_W-1:0] level,
  output logic             trig_hit,
  output logic             data_ready,
  output logic             overrun,
  output logic             brk,
  output logic             timeout_pend
);
  logic          en_q, dms_q;
  logic [1:0]    trig_q;
  logic [DW-1:0] hold_q, head, beat_byte;
  logic          dr_q, oe_q, bi_q, pend_q;
  logic          push_evt, rx_rst, accept, pop, ovr_set, rd_empties, expire;
  logic          tmr_restart, tmr_stop;
  logic [LVL_W-1:0] lvl_after;
  logic [TO_W-1:0]  reload;

  assign in_ready  = 1'b1;
  assign push_evt  = in_valid || in_break;
  assign beat_byte = in_break ? '0 : in_data;
  assign rx_rst    = fcr_wr && (fcr_data[1] || (fcr_data[0] != en_q));

  assign pop    = en_q && out_ready && (level != '0) && !rx_rst;
  assign accept = en_q && push_evt && !rx_rst &&
                  ((level < LVL_W'(DEPTH)) || pop);
  assign lvl_after = level + LVL_W'(accept) - LVL_W'(pop);

  assign ovr_set = push_evt && !rx_rst &&
                   (en_q ? !accept : (dr_q && !out_ready));
  assign rd_empties = out_ready && (en_q ? (lvl_after == '0) : !push_evt);

  assign reload      = TO_W'(4 * char_bits(lcr_wlen, lcr_par_en, lcr_stop2));
  assign tmr_restart = en_q && !rx_rst &&
                       (push_evt || (out_ready && (lvl_after != '0)));
  assign tmr_stop    = rx_rst || !en_q || (out_ready && (lvl_after == '0));

  uart_rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rx_rst), .push(accept), .pop(pop),
    .din(beat_byte), .dout(head), .level(level)
  );

  uart_rxq_timer #(.CW(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .restart(tmr_restart),
    .stop(tmr_stop), .reload(reload), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dms_q  <= 1'b0;
      trig_q <= 2'b00;
      hold_q <= '0;
      dr_q   <= 1'b0;
      oe_q   <= 1'b0;
      bi_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (fcr_wr) begin
        en_q   <= fcr_data[0];
        dms_q  <= fcr_data[3];
        trig_q <= fcr_data[7:6];
      end
      if (ovr_set)       oe_q <= 1'b1;
      else if (stat_clr) oe_q <= 1'b0;
      if (rx_rst) begin
        dr_q   <= 1'b0;
        bi_q   <= 1'b0;
        pend_q <= 1'b0;
        hold_q <= '0;
      end else begin
        if (rd_empties) begin
          dr_q <= 1'b0;
          bi_q <= 1'b0;
        end
        if (stat_clr) bi_q <= 1'b0;
        if (push_evt) begin
          dr_q <= 1'b1;
          if (in_break) bi_q <= 1'b1;
          if (!en_q) hold_q <= beat_byte;
        end
        if (out_ready)                      pend_q <= 1'b0;
        else if (expire && (level != '0))   pend_q <= 1'b1;
      end
    end
  end

  assign out_valid    = en_q ? (level != '0) : dr_q;
  assign out_data     = en_q ? ((level != '0) ? head : '0) : hold_q;
  assign fcr_q        = {trig_q, 2'b00, dms_q, 2'b00, en_q};
  assign trig_hit     = en_q ? (int'(level) >= trig_level(trig_q)) : dr_q;
  assign data_ready   = dr_q;
  assign overrun      = oe_q;
  assign brk          = bi_q;
  assign timeout_pend = pend_q;
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fcr_wr,
  input logic [7:0]       fcr_data,
  input logic             in_valid,
  input logic             in_break,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic [7:0]       fcr_q,
  input logic [LVL_W-1:0] level,
  input logic             data_ready,
  input logic             overrun,
  input logic             brk,
  input logic             timeout_pend
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R2

  AST_SAME_CYCLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_q[0] && in_valid && out_ready && (level != '0) && !fcr_wr
    |=> level == $past(level)); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_q[0] && (level == LVL_W'(DEPTH)) && in_valid && !out_ready && !fcr_wr
    |=> overrun && (level == LVL_W'(DEPTH))); // R3

  AST_TOUT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_pend) |-> level != '0); // R5

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_q[0] && (level == '0) |-> out_data == '0); // R6

  AST_READ_CLR_TOUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |=> !timeout_pend); // R6

  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr && fcr_data[1]
    |=> (level == '0) && !data_ready && !timeout_pend && !brk); // R8

  AST_FCR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr |=> fcr_q == ($past(fcr_data) & 8'hC9)); // R9

  AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    in_break && !fcr_wr |=> brk && data_ready); // R10
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_data(fcr_data),
  .in_valid(in_valid), .in_break(in_break), .out_ready(out_ready),
  .out_data(out_data), .fcr_q(fcr_q), .level(level),
  .data_ready(data_ready), .overrun(overrun), .brk(brk),
  .timeout_pend(timeout_pend)
);

// File: tb/sim_uart_rx_fifo.sv
`timescale 1ns/1ps
module sim_uart_rx_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic [1:0] lcr_wlen = 2'd3;
  logic       lcr_par_en = 1'b0, lcr_stop2 = 1'b0;
  logic       fcr_wr = 1'b0;
  logic [7:0] fcr_data = '0;
  logic       stat_clr = 1'b0;
  logic       in_valid = 1'b0, in_break = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, trig_hit, data_ready, overrun, brk, timeout_pend;
  logic [7:0] out_data, fcr_q;
  logic [4:0] level;

  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rx_fifo u0 (.*);

  function automatic int exp_trig(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 14;
  endfunction

  function automatic int exp_ticks(input int wl, input int par, input int s2);
    return 4 * (1 + 5 + wl + par + (s2 ? 2 : 1));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    cyc(1);
    in_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] exp, input string req);
    out_ready = 1'b1;
    #1;
    chk(out_data == exp, req, out_data, exp);
    cyc(1);
    out_ready = 1'b0;
  endtask

  task automatic fcr(input logic [7:0] v);
    fcr_wr = 1'b1; fcr_data = v;
    cyc(1);
    fcr_wr = 1'b0;
  endtask

  int q[$];
  int t;

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // reset state
    chk(level == 0 && !data_ready && !overrun && fcr_q == 8'h00 && in_ready,
        "R9 reset", level, 0);

    // R4: single-buffer mode
    push(8'hA1);
    chk(data_ready && out_data == 8'hA1, "R4 hold", out_data, 8'hA1);
    push(8'hB2);
    chk(overrun && out_data == 8'hB2, "R4 overrun newest", out_data, 8'hB2);
    rd_chk(8'hB2, "R4 read");
    chk(!data_ready, "R7 single read clears DR", data_ready, 0);
    stat_clr = 1'b1; cyc(1); stat_clr = 1'b0;
    chk(!overrun, "R3 stat_clr", overrun, 0);

    // R9: enable with all bits set, retained mask
    fcr(8'hFF);
    chk(fcr_q == 8'hC9, "R9 fcr mask", fcr_q, 8'hC9);
    push(8'h11); push(8'h22); push(8'h33);
    chk(level == 3, "R2 level", level, 3);
    fcr(8'h00);
    chk(level == 0 && !data_ready, "R9 disable flush", level, 0);
    fcr(8'h01);

    // R3: fill and overflow
    for (int i = 0; i < 17; i++) push(8'(8'h40 + i));
    chk(level == 16 && overrun, "R3 full overrun", level, 16);
    for (int i = 0; i < 16; i++) rd_chk(8'(8'h40 + i), "R3 contents kept");
    chk(!data_ready && level == 0, "R7 drain clears DR", data_ready, 0);
    stat_clr = 1'b1; cyc(1); stat_clr = 1'b0;
    chk(!overrun, "R3 overrun cleared", overrun, 0);
    rd_chk(8'h00, "R6 empty read zero");

    // R1: trigger thresholds
    for (int c = 0; c < 4; c++) begin
      fcr(8'(c << 6) | 8'h03);
      for (int i = 0; i < exp_trig(2'(c)) - 1; i++) push(8'h5A);
      chk(!trig_hit, "R1 below threshold", trig_hit, 0);
      push(8'h5A);
      chk(trig_hit, "R1 at threshold", trig_hit, 1);
    end
    fcr(8'h03);

    // R2: simultaneous push and read
    push(8'h01); push(8'h02);
    in_valid = 1'b1; in_data = 8'h03;
    rd_chk(8'h01, "R2 same-cycle read");
    in_valid = 1'b0;
    chk(level == 2, "R2 same-cycle level", level, 2);
    rd_chk(8'h02, "R2 order");
    rd_chk(8'h03, "R2 order");

    // R5: timeout, 8N1
    t = exp_ticks(3, 0, 0);
    push(8'h77); push(8'h78);
    cyc(t - 1);
    chk(!timeout_pend, "R5 not yet", timeout_pend, 0);
    cyc(1);
    chk(timeout_pend, "R5 fires", timeout_pend, 1);
    rd_chk(8'h77, "R6 read");
    chk(!timeout_pend, "R6 read clears pend", timeout_pend, 0);
    cyc(t);
    chk(timeout_pend, "R5 restart after read", timeout_pend, 1);
    rd_chk(8'h78, "R6 read");
    cyc(t + 5);
    chk(!timeout_pend, "R5 empty no pend", timeout_pend, 0);

    // R5: 5 data bits, parity, two stop bits
    lcr_wlen = 2'd0; lcr_par_en = 1'b1; lcr_stop2 = 1'b1;
    t = exp_ticks(0, 1, 1);
    push(8'h99);
    cyc(t - 1);
    chk(!timeout_pend, "R5 alt format early", timeout_pend, 0);
    cyc(1);
    chk(timeout_pend, "R5 alt format fires", timeout_pend, 1);

    // R10: break, then R8 flush
    in_break = 1'b1; cyc(1); in_break = 1'b0;
    chk(brk && data_ready && level == 2, "R10 break", level, 2);
    fcr(8'h03);
    chk(level == 0 && !data_ready && !brk && !timeout_pend, "R8 flush", level, 0);
    cyc(t + 2);
    chk(!timeout_pend, "R8 timer stopped", timeout_pend, 0);
    in_break = 1'b1; cyc(1); in_break = 1'b0;
    rd_chk(8'h00, "R10 zero byte");
    chk(!brk && !data_ready, "R7 break cleared", brk, 0);

    // random phase against a queue model
    lcr_wlen = 2'd3; lcr_par_en = 1'b0; lcr_stop2 = 1'b0;
    t = int'($urandom % 4);
    fcr(8'(t << 6) | 8'h03);
    q.delete();
    for (int i = 0; i < 600; i++) begin
      bit v, r, popped;
      logic [7:0] b;
      v = ($urandom % 100) < 55;
      r = ($urandom % 100) < 45;
      b = 8'($urandom);
      in_valid = v; in_data = b; out_ready = r;
      #1;
      chk(level == 5'(q.size()), "R2 random level", level, q.size());
      chk(trig_hit == (q.size() >= exp_trig(2'(t))), "R1 random trig", trig_hit,
          q.size() >= exp_trig(2'(t)));
      if (r) chk(out_data == ((q.size() != 0) ? 8'(q[0]) : 8'h00),
                 "R2 random data", out_data, (q.size() != 0) ? q[0] : 0);
      popped = r && (q.size() != 0);
      if (popped) void'(q.pop_front());
      if (v && (q.size() < 16)) q.push_back(int'(b));
      else if (v) begin
        cyc(1);
        in_valid = 1'b0; out_ready = 1'b0;
        chk(overrun, "R3 random overrun", overrun, 1);
        continue;
      end
      cyc(1);
      in_valid = 1'b0; out_ready = 1'b0;
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule